// File: doc/BRIEF.md
# PWM Channel Interrupt Flag Register

This block holds the interrupt status of one channel in a ring of ramp-based PWM channels. Hardware sets a sticky flag when any of these happens:
- the channel finishes a whole PWM cycle;
- an external event A or event B arrives (either event can cause a capture or a retrigger);
- the channel's timing drifts away from the channel before it in the ring.

In the ring, the channel before the first channel is the last one. This block only sees that neighbour's run strobe, so the ring order is set by how the parent wires the strobes together.

Software reads all flags as one byte. It clears a flag by writing a one to that flag's bit position. A two-bit field in the same byte shows which of the four ramps was active when the most recent event A or B arrived.

A single interrupt request line is raised whenever a set flag has its enable bit set. The flags are set whether or not their enables are on, so software can also poll them.

Top module: `pwm_irq_flags`

## Requirements
- R1: A one-cycle pulse on `cycle_end_i` makes bit 0 of `rd_data_o` read 1 from the clock edge that samples the pulse. The bit then stays 1 until it is cleared.
- R2: A pulse on `evt_a_i` sets bit 3 in the same way. This happens even when its enable (`irq_en_i[1]`) is 0.
- R3: A pulse on `evt_b_i` sets bit 4 in the same way. This happens even when its enable (`irq_en_i[2]`) is 0.
- R4: On every event A or B pulse, bits 2:1 load `ramp_idx_i` (00 = ramp 1, 01 = ramp 2, 10 = ramp 3, 11 = ramp 4). The field holds its value at all other times, resets to 00 and cannot be changed by a write.
- R5: Bit 5 (synchronization error) is set when both of these hold in the same cycle:
  - `auto_run_i` is 1;
  - exactly one of these two strobes is asserted: the local strobe (`upd_i` or `cycle_end_i`) and the neighbour's run strobe `master_run_i`.
- R6: Bit 5 is not set when `auto_run_i` is 0. It is also not set when the local strobe and `master_run_i` are asserted in the same cycle.
- R7: A write with `wr_en_i` high clears every flag bit (0, 3, 4, 5) whose `wr_data_i` bit is 1. A flag bit whose written bit is 0 keeps its value.
- R8: If a hardware set and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R9: `irq_o` is 1 exactly when at least one set flag has its enable bit set. The enable bits are: `irq_en_i[0]` for end of cycle, `[1]` for event A, `[2]` for event B and `[3]` for synchronization error. A change to the enables affects `irq_o` in the same cycle.
- R10: After reset, `rd_data_o` reads 0x00 and `irq_o` is 0. Bits 7:6 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cycle_end_i | input | 1 | Pulse: whole PWM cycle completed |
| evt_a_i | input | 1 | Pulse: external event A (capture/retrigger source) |
| evt_b_i | input | 1 | Pulse: external event B (capture/retrigger source) |
| upd_i | input | 1 | Pulse: this channel's update strobe |
| master_run_i | input | 1 | Pulse: run/update strobe of the preceding channel |
| auto_run_i | input | 1 | Channel is slaved to the preceding channel |
| ramp_idx_i | input | 2 | Current ramp, 00 = ramp 1 to 11 = ramp 4 |
| irq_en_i | input | 4 | Enables: [0] end of cycle, [1] event A, [2] event B, [3] sync error |
| wr_en_i | input | 1 | Write strobe for the flag register |
| wr_data_i | input | 8 | Write data, a one clears the flag at that bit |
| rd_data_o | output | 8 | Flag byte: [5] sync, [4] B, [3] A, [2:1] ramp, [0] end of cycle |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Every flag and the ramp field has exactly one register between the input pulse or write and `rd_data_o`. A result is therefore due at the first rising edge that samples the stimulus. `irq_o` follows the flags and the enables with no further delay.

The bench changes inputs on the falling edge and holds each pulse for one full cycle. It reads the outputs on the next falling edge, half a cycle after the edge that updates them. For the same-cycle cases (the coincidence test and set against clear), both stimuli are driven on the same falling edge, so one rising edge sees them together.

// File: rtl/pwm_irq_pkg.sv
// Shared constants for the PWM channel interrupt flag register.
// Assumes the fixed byte layout used by the software read path.
package pwm_irq_pkg;
    localparam int REG_W     = 8;
    localparam int RAMP_W    = 2;
    localparam int N_SRC     = 4;
    localparam int EN_W      = N_SRC;
    // Bit positions inside the readable byte
    localparam int POS_EOC   = 0;
    localparam int POS_RAMP  = 1;
    localparam int POS_EVA   = 3;
    localparam int POS_EVB   = 4;
    localparam int POS_SYNC  = 5;
    // Source index order used for flags and enables
    typedef enum logic [1:0] {
        SRC_EOC  = 2'd0,
        SRC_EVA  = 2'd1,
        SRC_EVB  = 2'd2,
        SRC_SYNC = 2'd3
    } src_e;
endpackage

// File: rtl/w1c_flag_bank.sv
// Bank of sticky flags, set by hardware and cleared by writing a one.
// Assumes set_i and clr_i are already aligned to the same index order.
// A set in the same cycle as a clear wins.
module w1c_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Hold one sticky flag: reset, set priority, then clear
        always_ff @(posedge clk) begin
            if (!rst_n)        q_o[i] <= 1'b0;
            else if (set_i[i]) q_o[i] <= 1'b1;
            else if (clr_i[i]) q_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/sync_mismatch.sv
// Detects a cycle in which the local timing strobe and the preceding
// channel's run strobe disagree while auto-run is on.
// Assumes both strobes are single-cycle pulses in the same clock domain.
module sync_mismatch (
    input  logic auto_run_i,
    input  logic upd_i,
    input  logic cycle_end_i,
    input  logic master_run_i,
    output logic err_o
);
    logic local_strobe;

    // Combine the local strobes and compare them with the master strobe
    always_comb begin
        local_strobe = upd_i | cycle_end_i;
        err_o        = auto_run_i & (local_strobe ^ master_run_i);
    end
endmodule

// File: rtl/ramp_capture.sv
// Remembers which ramp was active at the most recent event A or B.
// The field is read-only to software and resets to the first ramp.
module ramp_capture #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt_i,
    input  logic [W-1:0] ramp_i,
    output logic [W-1:0] q_o
);
    // Load the ramp index on each event, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= '0;
        else if (evt_i) q_o <= ramp_i;
    end
endmodule

// File: rtl/pwm_irq_flags.sv
// Interrupt flag register for one channel of a chained PWM controller.
// Collects end-of-cycle, event A/B and synchronization error flags,
// the ramp number of the last event, and a combined interrupt request.
// Assumes all strobes are single-cycle and synchronous to clk.
module pwm_irq_flags
    import pwm_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cycle_end_i,
    input  logic              evt_a_i,
    input  logic              evt_b_i,
    input  logic              upd_i,
    input  logic              master_run_i,
    input  logic              auto_run_i,
    input  logic [RAMP_W-1:0] ramp_idx_i,
    input  logic [EN_W-1:0]   irq_en_i,
    input  logic              wr_en_i,
    input  logic [REG_W-1:0]  wr_data_i,
    output logic [REG_W-1:0]  rd_data_o,
    output logic              irq_o
);
    logic [N_SRC-1:0]  set_vec;
    logic [N_SRC-1:0]  clr_vec;
    logic [N_SRC-1:0]  flags;
    logic [RAMP_W-1:0] ramp_q;
    logic              sync_err;

    sync_mismatch u_sync (
        .auto_run_i   (auto_run_i),
        .upd_i        (upd_i),
        .cycle_end_i  (cycle_end_i),
        .master_run_i (master_run_i),
        .err_o        (sync_err)
    );

    // Gather the hardware set requests in source order
    always_comb begin
        set_vec           = '0;
        set_vec[SRC_EOC]  = cycle_end_i;
        set_vec[SRC_EVA]  = evt_a_i;
        set_vec[SRC_EVB]  = evt_b_i;
        set_vec[SRC_SYNC] = sync_err;
    end

    // Map write-one-to-clear data bits onto the source order
    always_comb begin
        clr_vec           = '0;
        clr_vec[SRC_EOC]  = wr_en_i & wr_data_i[POS_EOC];
        clr_vec[SRC_EVA]  = wr_en_i & wr_data_i[POS_EVA];
        clr_vec[SRC_EVB]  = wr_en_i & wr_data_i[POS_EVB];
        clr_vec[SRC_SYNC] = wr_en_i & wr_data_i[POS_SYNC];
    end

    w1c_flag_bank #(.N(N_SRC)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .clr_i (clr_vec),
        .q_o   (flags)
    );

    ramp_capture #(.W(RAMP_W)) u_ramp (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_a_i | evt_b_i),
        .ramp_i (ramp_idx_i),
        .q_o    (ramp_q)
    );

    // Assemble the readable byte; unused bits stay zero
    always_comb begin
        rd_data_o                             = '0;
        rd_data_o[POS_EOC]                    = flags[SRC_EOC];
        rd_data_o[POS_RAMP +: RAMP_W]         = ramp_q;
        rd_data_o[POS_EVA]                    = flags[SRC_EVA];
        rd_data_o[POS_EVB]                    = flags[SRC_EVB];
        rd_data_o[POS_SYNC]                   = flags[SRC_SYNC];
    end

    // Request an interrupt when any enabled flag is pending
    always_comb begin
        irq_o = |(flags & irq_en_i);
    end
endmodule

// File: rtl/pwm_irq_flags_chk.sv
// Property checker for pwm_irq_flags, attached with bind.
// Observes only the ports of the design.
module pwm_irq_flags_chk
    import pwm_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cycle_end_i,
    input logic              evt_a_i,
    input logic              evt_b_i,
    input logic              upd_i,
    input logic              master_run_i,
    input logic              auto_run_i,
    input logic [RAMP_W-1:0] ramp_idx_i,
    input logic [EN_W-1:0]   irq_en_i,
    input logic              wr_en_i,
    input logic [REG_W-1:0]  wr_data_i,
    input logic [REG_W-1:0]  rd_data_o,
    input logic              irq_o
);
    assert_eoc_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end_i |=> rd_data_o[POS_EOC]);

    assert_eva_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_a_i |=> rd_data_o[POS_EVA]);

    assert_evb_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_b_i |=> rd_data_o[POS_EVB]);

    assert_ramp_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_a_i || evt_b_i) |=> rd_data_o[POS_RAMP +: RAMP_W] == $past(ramp_idx_i));

    assert_ramp_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_a_i || evt_b_i) |=> $stable(rd_data_o[POS_RAMP +: RAMP_W]));

    assert_sync_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_run_i && ((upd_i || cycle_end_i) != master_run_i)) |=> rd_data_o[POS_SYNC]);

    assert_sync_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data_o[POS_SYNC] && !(auto_run_i && ((upd_i || cycle_end_i) != master_run_i)))
        |=> !rd_data_o[POS_SYNC]);

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_data_i[POS_EOC] && !cycle_end_i) |=> !rd_data_o[POS_EOC]);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o[POS_EVA] && !(wr_en_i && wr_data_i[POS_EVA])) |=> rd_data_o[POS_EVA]);

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_b_i && wr_en_i && wr_data_i[POS_EVB]) |=> rd_data_o[POS_EVB]);

    assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == ((rd_data_o[POS_EOC] && irq_en_i[0]) || (rd_data_o[POS_EVA] && irq_en_i[1]) ||
                  (rd_data_o[POS_EVB] && irq_en_i[2]) || (rd_data_o[POS_SYNC] && irq_en_i[3])));

    assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[7:6] == 2'b00);
endmodule

bind pwm_irq_flags pwm_irq_flags_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cycle_end_i  (cycle_end_i),
    .evt_a_i      (evt_a_i),
    .evt_b_i      (evt_b_i),
    .upd_i        (upd_i),
    .master_run_i (master_run_i),
    .auto_run_i   (auto_run_i),
    .ramp_idx_i   (ramp_idx_i),
    .irq_en_i     (irq_en_i),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .rd_data_o    (rd_data_o),
    .irq_o        (irq_o)
);

// File: tb/sim_pwm_irq_flags.sv
// Directed bench for pwm_irq_flags: inputs change on the falling edge,
// outputs are read on the following falling edge.
module sim_pwm_irq_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cycle_end_i = 1'b0, evt_a_i = 1'b0, evt_b_i = 1'b0, upd_i = 1'b0;
    logic       master_run_i = 1'b0, auto_run_i = 1'b0;
    logic [1:0] ramp_idx_i = 2'b00;
    logic [3:0] irq_en_i = 4'b0000;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] rd_data_o;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pwm_irq_flags u0 (
        .clk(clk), .rst_n(rst_n), .cycle_end_i(cycle_end_i), .evt_a_i(evt_a_i),
        .evt_b_i(evt_b_i), .upd_i(upd_i), .master_run_i(master_run_i),
        .auto_run_i(auto_run_i), .ramp_idx_i(ramp_idx_i), .irq_en_i(irq_en_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Advance one cycle and return all pulses to idle
    task automatic step();
        @(negedge clk);
        cycle_end_i = 0; evt_a_i = 0; evt_b_i = 0; upd_i = 0;
        master_run_i = 0; wr_en_i = 0; wr_data_i = 8'h00;
    endtask

    task automatic write(input logic [7:0] d);
        wr_en_i = 1; wr_data_i = d;
        step();
    endtask

    task automatic t_reset();
        check("R10 reset byte", rd_data_o, 8'h00);
        check("R10 reset irq", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic t_end_of_cycle();
        cycle_end_i = 1; step();
        check("R1 eoc flag", rd_data_o, 8'h01);
        write(8'h00);
        check("R7 write zero keeps", rd_data_o, 8'h01);
        write(8'h01);
        check("R7 clear eoc", rd_data_o, 8'h00);
    endtask

    task automatic t_events();
        irq_en_i = 4'b0000;
        ramp_idx_i = 2'b10; evt_a_i = 1; step();
        check("R2 eva with enable off", rd_data_o, 8'h0C);
        check("R9 irq masked", {7'b0, irq_o}, 8'h00);
        ramp_idx_i = 2'b11; evt_b_i = 1; step();
        check("R3 evb and R4 ramp 4", rd_data_o, 8'h1E);
        ramp_idx_i = 2'b00;
        write(8'h06);
        check("R4 ramp field read-only", rd_data_o, 8'h1E);
        write(8'h18);
        check("R7 clear events, R4 ramp held", rd_data_o, 8'h06);
        for (int r = 0; r < 4; r++) begin
            ramp_idx_i = r[1:0]; evt_b_i = 1; step();
            check("R4 ramp encoding", rd_data_o[2:1], r[7:0]);
        end
        write(8'h10);
    endtask

    task automatic t_sync();
        auto_run_i = 1;
        step();
        check("R6 idle no error", {7'b0, rd_data_o[5]}, 8'h00);
        upd_i = 1; step();
        check("R5 local only", {7'b0, rd_data_o[5]}, 8'h01);
        write(8'h20);
        master_run_i = 1; step();
        check("R5 master only", {7'b0, rd_data_o[5]}, 8'h01);
        write(8'h20);
        upd_i = 1; master_run_i = 1; step();
        check("R6 coincident upd", {7'b0, rd_data_o[5]}, 8'h00);
        cycle_end_i = 1; master_run_i = 1; step();
        check("R6 coincident eoc", {7'b0, rd_data_o[5]}, 8'h00);
        write(8'h01);
        auto_run_i = 0;
        upd_i = 1; step();
        check("R6 auto-run off", {7'b0, rd_data_o[5]}, 8'h00);
        cycle_end_i = 1; step();
        check("R6 auto-run off eoc", rd_data_o & 8'h21, 8'h01);
        write(8'h01);
    endtask

    task automatic t_set_wins();
        evt_a_i = 1; ramp_idx_i = 2'b00; wr_en_i = 1; wr_data_i = 8'h08; step();
        check("R8 set beats clear", {7'b0, rd_data_o[3]}, 8'h01);
        write(8'h08);
        check("R7 cleared afterwards", {7'b0, rd_data_o[3]}, 8'h00);
    endtask

    task automatic t_irq();
        irq_en_i = 4'b0000;
        evt_b_i = 1; step();
        check("R9 flag set enable off", {7'b0, irq_o}, 8'h00);
        irq_en_i = 4'b0001; #1;
        check("R9 wrong enable", {7'b0, irq_o}, 8'h00);
        irq_en_i = 4'b0100; #1;
        check("R9 matching enable", {7'b0, irq_o}, 8'h01);
        write(8'h10);
        check("R9 drop after clear", {7'b0, irq_o}, 8'h00);
        irq_en_i = 4'b1000; auto_run_i = 1; master_run_i = 1; step();
        check("R9 sync enable", {7'b0, irq_o}, 8'h01);
        auto_run_i = 0;
        write(8'h20);
        irq_en_i = 4'b0000;
        check("R10 final clean", rd_data_o & 8'hF9, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        step();
        t_reset();
        t_end_of_cycle();
        t_events();
        t_sync();
        t_set_wins();
        t_irq();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule